// File: doc/BRIEF.md
# Manchester Line Encoder for 10 Mb/s Ethernet

This block sits between a MAC-side controller and the analog line driver of a 10 Mb/s Ethernet port. It runs from a 20 MHz reference clock. It divides that clock by two to produce a 10 MHz transmit clock for the controller. On each rising edge of that transmit clock it samples a transmit-enable and a transmit-data bit. While enable is sampled high, each data bit becomes two 50 ns half-cells on a single-bit line output. A one is sent as low then high, and a zero as high then low.

The line rests high when no packet is in progress. Because of this, the first level change of any packet is always a falling one, whatever the first data bit is. When enable is first sampled low after packet data, the encoder holds the line high for a fixed number of reference cycles. This forms the end-of-packet idle pulse, after which the block returns to rest. A line-active flag marks the whole span from the first coded half-cell to the end of that pulse. It tells the downstream driver when to drive the line. If enable comes back during the pulse, the new packet waits until the pulse has finished.

Top module: `manch_tx_encoder`

## Requirements
- R1: While rst_n is low, and on the first clock after it, line_o is 1, line_active_o is 0 and txc_o is 1.
- R2: txc_o changes level on every clock edge after reset, giving a clock at half the reference rate with equal high and low phases of one reference cycle each.
- R3: txe_i and txd_i are sampled only on the clock edges where txc_o rises. A bit cell begins on that same edge.
- R4: A sampled data bit occupies two reference cycles on line_o. A 1 is sent as 0 then 1, and a 0 is sent as 1 then 0, so every bit cell changes level at its middle.
- R5: While no packet is active, line_o stays 1 and line_active_o stays 0, whatever txd_i does.
- R6: After line_active_o rises, the first change of line_o is from 1 to 0.
- R7: On the first sampling edge where txe_i is low after packet data, line_o goes (or stays) 1 and remains 1 for exactly EOP_CYCLES reference cycles with line_active_o high. line_active_o then drops. The default is 6 cycles, which is 300 ns at 20 MHz.
- R8: A txe_i that is high during the end-of-packet pulse has no effect until the pulse ends. The next packet then starts at the first sampling edge after the pulse, which leaves line_active_o low for exactly two cycles when EOP_CYCLES is even.
- R9: line_active_o is high from the first coded half-cell of a packet through the last cycle of its end-of-packet pulse, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txe_i | input | 1 | Transmit enable from the controller, synchronous to txc_o |
| txd_i | input | 1 | NRZ transmit data from the controller, synchronous to txc_o |
| txc_o | output | 1 | 10 MHz transmit clock to the controller |
| line_o | output | 1 | Manchester-coded line level |
| line_active_o | output | 1 | High while a packet or its end-of-packet pulse is on the line |

## Verification
The hardest situation to reach is a transmit enable that returns while the end-of-packet pulse is still running. Reaching it needs the enable to drop for exactly one sampling edge and then rise again before the pulse finishes. The stimulus does this by lowering enable for one two-cycle bit period between two bursts of data. It then measures the gap in line_active_o. A second burst is offset by a single reference cycle, so that the enable edge lands in the middle of a transmit-clock period.

// File: rtl/mte_pkg.sv
// Shared types for the Manchester transmit encoder.
// Assumes: one clock domain, the 20 MHz reference.
package mte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // line at rest, high
        ST_DATA = 2'd1,   // coding sampled bits
        ST_EOP  = 2'd2    // end-of-packet idle pulse
    } tx_state_e;
endpackage

// File: rtl/mte_txc_div.sv
// Divide-by-two of the reference clock into the transmit clock.
// Produces txc_o and a strobe marking the reference edge on which txc_o
// rises, which is where inputs are sampled and bit cells begin.
// Assumes: synchronous active-low reset, txc_o high while in reset.
module mte_txc_div (
    input  logic clk,
    input  logic rst_n,
    output logic txc_o,
    output logic bit_edge_o
);
    logic ph_q;   // 0: first half-cell, 1: second half-cell

    // Phase toggle, one half-cell per reference cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign txc_o      = ~ph_q;
    assign bit_edge_o = ph_q;

    // R2
    txc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (txc_o != $past(txc_o)));
endmodule

// File: rtl/mte_eop_timer.sv
// Down-counter that times the end-of-packet idle pulse.
// load_i arms it to EOP_CYCLES-1; while run_i is high it counts down, and
// done_o flags the last cycle of the pulse.
// Assumes: EOP_CYCLES >= 1, load_i and run_i never high together.
module mte_eop_timer #(
    parameter int EOP_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (EOP_CYCLES > 1) ? $clog2(EOP_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(EOP_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Arm on pulse start, count down while the pulse runs
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load_i)                   cnt_q <= LOAD_VAL;
        else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = run_i && (cnt_q == '0);

    // R7
    eop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);
    // R7
    eop_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/mte_cell_gen.sv
// Packet state machine and half-cell generator.
// On each bit edge it samples enable and data; it writes the first half-cell
// (inverse of the bit) there and the second half-cell (the bit) one cycle
// later. It opens the end-of-packet pulse when enable drops, and returns to
// rest when the timer expires.
// Assumes: bit_edge_i is high on alternate cycles; the line rests high.
module mte_cell_gen
    import mte_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_edge_i,
    input  logic txe_i,
    input  logic txd_i,
    input  logic eop_done_i,
    output logic eop_load_o,
    output logic eop_run_o,
    output logic line_o,
    output logic active_o
);
    tx_state_e state_q;
    logic      bit_q;
    logic      line_q;

    assign eop_load_o = bit_edge_i && (state_q == ST_DATA) && !txe_i;
    assign eop_run_o  = (state_q == ST_EOP);

    // Packet sequencing and line level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= 1'b0;
            line_q  <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (bit_edge_i && txe_i) begin
                        state_q <= ST_DATA;
                        bit_q   <= txd_i;
                        line_q  <= ~txd_i;
                    end else begin
                        line_q  <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_edge_i) begin
                        if (txe_i) begin
                            bit_q  <= txd_i;
                            line_q <= ~txd_i;
                        end else begin
                            state_q <= ST_EOP;
                            line_q  <= 1'b1;
                        end
                    end else begin
                        line_q <= bit_q;
                    end
                end
                ST_EOP: begin
                    line_q <= 1'b1;
                    if (eop_done_i) state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    line_q  <= 1'b1;
                end
            endcase
        end
    end

    assign line_o   = line_q;
    assign active_o = (state_q != ST_IDLE);

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> line_o);
    // R4
    mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_DATA && bit_edge_i)
            |-> (line_o != $past(line_o)));
    // R6
    first_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active_o) && line_o) |=> !line_o);
    // R7
    eop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOP) |-> (line_o && active_o));
    // R3
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bit_edge_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/manch_tx_encoder.sv
// Top of the 10 Mb/s Manchester transmit encoder.
// Wires the transmit-clock divider, the half-cell generator and the
// end-of-packet timer together.
// Assumes: clk is the 20 MHz reference; txe_i/txd_i change only after a
// rising txc_o and are stable at the next one.
module manch_tx_encoder #(
    parameter int EOP_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txe_i,
    input  logic txd_i,
    output logic txc_o,
    output logic line_o,
    output logic line_active_o
);
    logic bit_edge;
    logic eop_load;
    logic eop_run;
    logic eop_done;

    mte_txc_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .txc_o      (txc_o),
        .bit_edge_o (bit_edge)
    );

    mte_cell_gen u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_edge_i (bit_edge),
        .txe_i      (txe_i),
        .txd_i      (txd_i),
        .eop_done_i (eop_done),
        .eop_load_o (eop_load),
        .eop_run_o  (eop_run),
        .line_o     (line_o),
        .active_o   (line_active_o)
    );

    mte_eop_timer #(.EOP_CYCLES(EOP_CYCLES)) u_eop (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (eop_load),
        .run_i  (eop_run),
        .done_o (eop_done)
    );
endmodule

// File: tb/manch_tx_encoder_test.sv
module manch_tx_encoder_test;
    localparam int EOP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txe = 1'b0;
    logic txd = 1'b0;
    logic txc, line, act;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural reference state
    int m_ph = 0, m_mode = 0, m_bit = 0, m_cnt = 0, m_line = 1;
    int prev_act = 0, prev_line = 1, armed = 0;
    int gap = 0, last_gap = -1, eop_len = 0, in_eop = 0;

    manch_tx_encoder #(.EOP_CYCLES(EOP)) uut (
        .clk(clk), .rst_n(rst_n), .txe_i(txe), .txd_i(txd),
        .txc_o(txc), .line_o(line), .line_active_o(act)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic model_step(input int e, input int d);
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_bit = 0; m_cnt = 0; m_line = 1;
            return;
        end
        if (m_mode == 2) begin
            m_line = 1;
            if (m_cnt == 0) m_mode = 0; else m_cnt--;
        end else if (m_ph == 1) begin
            if (m_mode == 0) begin
                if (e != 0) begin m_mode = 1; m_bit = d; m_line = (d != 0) ? 0 : 1; end
                else m_line = 1;
            end else begin
                if (e != 0) begin m_bit = d; m_line = (d != 0) ? 0 : 1; end
                else begin m_mode = 2; m_line = 1; m_cnt = EOP - 1; end
            end
        end else begin
            if (m_mode == 1) m_line = m_bit; else m_line = 1;
        end
        m_ph = 1 - m_ph;
    endtask

    task automatic compare();
        int exp_act;
        exp_act = (m_mode != 0) ? 1 : 0;
        check(txc == (m_ph == 0), "R2 txc", txc, (m_ph == 0));
        check(line == m_line, "R3 R4 line", line, m_line);
        check(act == exp_act, "R9 active", act, exp_act);
        if (m_mode == 2) check(line == 1, "R7 eop level", line, 1);
        if (m_mode == 0 && rst_n) check(line == 1, "R5 idle level", line, 1);
        // first transition of each packet must fall
        if (act && !prev_act) armed = 1;
        if (armed && line != prev_line) begin
            check(line == 0, "R6 first edge", line, 0);
            armed = 0;
        end
        // end-of-packet pulse length
        if (m_mode == 2 && act) begin in_eop = 1; eop_len++; end
        if (!act && prev_act && in_eop) begin
            check(eop_len == EOP, "R7 eop length", eop_len, EOP);
            in_eop = 0; eop_len = 0;
        end
        // idle gap between packets
        if (!act) gap++;
        if (act && !prev_act) begin last_gap = gap; end
        if (act) gap = 0;
        prev_act = act; prev_line = line;
    endtask

    task automatic cyc(input int e, input int d);
        txe = e[0]; txd = d[0];
        @(posedge clk);
        model_step(e, d);
        @(negedge clk);
        compare();
    endtask

    task automatic send_bit(input int d);
        cyc(1, d); cyc(1, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(line == 1, "R1 line", line, 1);
        check(act == 0, "R1 active", act, 0);
        check(txc == 1, "R1 txc", txc, 1);
        rst_n = 1'b1;
        cyc(0, 0);
        check(line == 1 && act == 0, "R1 first cycle", act, 0);
        // R5 txd toggling with enable low
        for (int i = 0; i < 8; i++) cyc(0, i % 2);
        check(act == 0 && line == 1, "R5 ignored txd", act, 0);
        // packet A: starts with 1
        begin
            int pa[10] = '{1, 0, 1, 0, 1, 1, 0, 0, 1, 0};
            for (int i = 0; i < 10; i++) send_bit(pa[i]);
        end
        for (int i = 0; i < 14; i++) cyc(0, 1);
        // packet B: starts with 0, then enable returns during the pulse
        send_bit(0); send_bit(1); send_bit(1);
        cyc(0, 0); cyc(0, 0);
        for (int i = 0; i < 5; i++) send_bit(1);
        check(last_gap == 2, "R8 holdoff gap", last_gap, 2);
        send_bit(0); send_bit(1);
        for (int i = 0; i < 14; i++) cyc(0, 0);
        // packet C: offset by one reference cycle
        cyc(0, 0);
        send_bit(0); send_bit(0); send_bit(1); send_bit(1);
        for (int i = 0; i < 14; i++) cyc(0, 0);
        check(act == 0 && line == 1, "R9 back to rest", act, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule